// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block is the sending half of an interprocessor interrupt path. Software programs a two-word command register through a plain register port. The high word names the target processor. A write to the low word captures the message fields and starts the send. The captured message goes out on a single valid/ready handshake. That handshake carries the resolved destination, vector, delivery mode, trigger mode, level flag and destination shorthand.

While the message waits for the handshake, a delivery-status bit in the low word reads 1, and software polls it until it returns to 0. Two rules protect a message in flight:

- A second low-word write made during that time is dropped and a sticky error flag is raised.
- A high-word write made during that time only prepares the next message.

A remote-read status field in the low word follows messages sent in remote-read mode.

The sender is a two-state machine:

- **ST_IDLE**: no message pending. A low-word write takes the transition **LAUNCH** to ST_SEND and captures the fields.
- **ST_SEND**: `msg_valid` is high. When `msg_ready` is seen, the transition **ACCEPT** returns to ST_IDLE. A low-word write seen in ST_SEND takes the self-loop **DROP**, which sets the error flag. Without `msg_ready`, the self-loop **HOLD** keeps every field unchanged.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset `msg_valid` is 0, `drop_err` is 0, and the low and high words both read as zero.
- R2: A write to offset 0x310 stores bits 31:24 as the target identifier. Reading 0x310 returns that identifier in bits 31:24 and zero in every other bit. Any offset other than 0x300 and 0x310 reads as zero.
- R3: A write to offset 0x300 made in ST_IDLE raises `msg_valid` on the next cycle. The message fields come from the written word: vector from bits 7:0, delivery mode from bits 10:8 (000 fixed, 011 remote read, 100 NMI, 101 INIT, 110 startup), level flag from bit 14 (1 assert, 0 deassert), trigger mode from bit 15 (1 level), and shorthand from bits 19:18.
- R4: The destination is resolved at launch from the shorthand code. Code 00 uses the stored target identifier. Code 01 uses `self_id`. Codes 10 (all including self) and 11 (all excluding self) give 0xFF. `msg_short` carries the code unchanged.
- R5: Bit 12 of the low-word readback reads 1 from the cycle after a launch until the ACCEPT handshake. It reads 0 from the cycle after the edge where `msg_valid` and `msg_ready` are both high.
- R6: While `msg_valid` is high and `msg_ready` is low, every message output holds its value.
- R7: A low-word write made in ST_SEND is ignored and the message outputs keep their values. `drop_err` becomes 1 on the next cycle and stays 1 until the next accepted launch clears it.
- R8: A high-word write made in ST_SEND changes the stored identifier but not `msg_dest` of the message in flight.
- R9: Bits 17:16 of the low-word readback report remote-read status. The value is 01 from a launch in mode 011 until its handshake, and 10 after that handshake. It is 00 after reset and after a launch in any other mode.
- R10: For a startup message, the vector field carries the start address divided by 4096 and goes out unchanged.
- R11: The low-word readback returns the captured vector, mode, level, trigger and shorthand in their written bit positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_id | input | 8 | Identifier of the local processor |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| msg_valid | output | 1 | Outbound message present |
| msg_ready | input | 1 | Outbound message accepted |
| msg_dest | output | 8 | Resolved destination identifier |
| msg_vector | output | 8 | Interrupt vector or startup page number |
| msg_mode | output | 3 | Delivery mode |
| msg_trig | output | 1 | Trigger mode, 1 means level |
| msg_level | output | 1 | Level flag, 1 means assert |
| msg_short | output | 2 | Destination shorthand code |
| drop_err | output | 1 | Sticky flag for a launch dropped while busy |

## Verification
The assertions check the handshake rules on every cycle:

- A message is held steady while it is not accepted.
- `msg_valid` falls after acceptance.
- A low-word write in ST_IDLE launches a message, and one in ST_SEND sets the error flag.
- The self and broadcast destinations always resolve correctly.

The bench's scenarios cover the following:

- The full field mapping and readback across every shorthand, several delivery modes, both level values and varied acceptance delays.
- The sequence of the remote-read status field.
- The isolation of an in-flight destination from a later high-word write.
- The clearing of the error flag by the next launch.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int ID_W    = 8;
    localparam int VEC_W   = 8;
    localparam int MODE_W  = 3;
    localparam int SH_W    = 2;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 12;

    localparam logic [ADDR_W-1:0] OFF_LO = 12'h300;
    localparam logic [ADDR_W-1:0] OFF_HI = 12'h310;

    // bit positions inside the command words
    localparam int B_VEC   = 0;
    localparam int B_MODE  = 8;
    localparam int B_BUSY  = 12;
    localparam int B_LEVEL = 14;
    localparam int B_TRIG  = 15;
    localparam int B_RR    = 16;
    localparam int B_SH    = 18;
    localparam int B_ID    = 24;

    localparam logic [ID_W-1:0] ID_BCAST = '1;

    typedef enum logic [SH_W-1:0] {
        SH_FIELD   = 2'b00,
        SH_SELF    = 2'b01,
        SH_ALL_INC = 2'b10,
        SH_ALL_EXC = 2'b11
    } short_e;

    typedef enum logic [MODE_W-1:0] {
        DM_FIXED = 3'b000,
        DM_RREAD = 3'b011,
        DM_NMI   = 3'b100,
        DM_INIT  = 3'b101,
        DM_START = 3'b110
    } dmode_e;

    typedef enum logic [1:0] {
        RR_NONE = 2'b00,
        RR_PEND = 2'b01,
        RR_DONE = 2'b10
    } rr_e;

    typedef struct packed {
        logic [ID_W-1:0]  dest;
        short_e           sh;
        logic             trig;
        logic             level;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0] vec;
    } msg_t;
endpackage

// File: rtl/ipi_dest_sel.sv
module ipi_dest_sel
    import ipi_pkg::*;
(
    input  short_e          sh,
    input  logic [ID_W-1:0] field_id,
    input  logic [ID_W-1:0] self_id,
    output logic [ID_W-1:0] dest
);
    always_comb begin
        unique case (sh)
            SH_FIELD:   dest = field_id;
            SH_SELF:    dest = self_id;
            SH_ALL_INC: dest = ID_BCAST;
            SH_ALL_EXC: dest = ID_BCAST;
            default:    dest = field_id;
        endcase
    end
endmodule

// File: rtl/ipi_send_fsm.sv
module ipi_send_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_req,
    input  logic msg_ready,
    output logic busy,
    output logic launch_ok,
    output logic drop,
    output logic done
);
    typedef enum logic {ST_IDLE, ST_SEND} state_e;
    state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (launch_req) state_nx = ST_SEND;   // LAUNCH
            ST_SEND: if (msg_ready)  state_nx = ST_IDLE;   // ACCEPT
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        launch_ok = 1'b0;
        drop      = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: launch_ok = launch_req;
            ST_SEND: begin
                busy = 1'b1;
                drop = launch_req;       // DROP
                done = msg_ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ipi_regs.sv
module ipi_regs
    import ipi_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LO_ADDR = OFF_LO,
    parameter logic [ADDR_W-1:0] HI_ADDR = OFF_HI
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              launch_ok,
    input  logic              drop,
    input  logic              done,
    input  logic              busy,
    input  logic [ID_W-1:0]   dest_in,
    output logic [ID_W-1:0]   hi_id,
    output msg_t              msg,
    output logic [REG_W-1:0]  rdata,
    output logic              err
);
    rr_e  rr;
    logic hi_wr;

    assign hi_wr = we && (addr == HI_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_id <= '0;
            msg   <= '0;
            rr    <= RR_NONE;
            err   <= 1'b0;
        end else begin
            if (hi_wr) hi_id <= wdata[B_ID +: ID_W];
            if (launch_ok) begin
                msg.dest  <= dest_in;
                msg.sh    <= short_e'(wdata[B_SH +: SH_W]);
                msg.trig  <= wdata[B_TRIG];
                msg.level <= wdata[B_LEVEL];
                msg.mode  <= wdata[B_MODE +: MODE_W];
                msg.vec   <= wdata[B_VEC +: VEC_W];
                rr  <= (wdata[B_MODE +: MODE_W] == DM_RREAD) ? RR_PEND : RR_NONE;
                err <= 1'b0;
            end else begin
                if (drop) err <= 1'b1;
                if (done && rr == RR_PEND) rr <= RR_DONE;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == LO_ADDR) begin
            rdata[B_VEC  +: VEC_W]  = msg.vec;
            rdata[B_MODE +: MODE_W] = msg.mode;
            rdata[B_BUSY]           = busy;
            rdata[B_LEVEL]          = msg.level;
            rdata[B_TRIG]           = msg.trig;
            rdata[B_RR   +: 2]      = rr;
            rdata[B_SH   +: SH_W]   = msg.sh;
        end else if (addr == HI_ADDR) begin
            rdata[B_ID +: ID_W] = hi_id;
        end
    end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
    import ipi_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LO_ADDR = OFF_LO,
    parameter logic [ADDR_W-1:0] HI_ADDR = OFF_HI
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ID_W-1:0]     self_id,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [ID_W-1:0]     msg_dest,
    output logic [VEC_W-1:0]    msg_vector,
    output logic [MODE_W-1:0]   msg_mode,
    output logic                msg_trig,
    output logic                msg_level,
    output logic [SH_W-1:0]     msg_short,
    output logic                drop_err
);
    logic            launch_req, launch_ok, drop, done, busy;
    logic [ID_W-1:0] hi_id, dest_res;
    msg_t            msg;

    assign launch_req = reg_we && (reg_addr == LO_ADDR);

    ipi_send_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .launch_req(launch_req), .msg_ready(msg_ready),
        .busy(busy), .launch_ok(launch_ok), .drop(drop), .done(done)
    );

    ipi_dest_sel u_dsel (
        .sh(short_e'(reg_wdata[B_SH +: SH_W])), .field_id(hi_id),
        .self_id(self_id), .dest(dest_res)
    );

    ipi_regs #(.LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .launch_ok(launch_ok), .drop(drop), .done(done), .busy(busy),
        .dest_in(dest_res), .hi_id(hi_id), .msg(msg), .rdata(reg_rdata), .err(drop_err)
    );

    assign msg_valid  = busy;
    assign msg_dest   = msg.dest;
    assign msg_vector = msg.vec;
    assign msg_mode   = msg.mode;
    assign msg_trig   = msg.trig;
    assign msg_level  = msg.level;
    assign msg_short  = msg.sh;
endmodule

// File: rtl/ipi_cmd_chk.sv
module ipi_cmd_chk
    import ipi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ID_W-1:0]   self_id,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [ID_W-1:0]   msg_dest,
    input logic [VEC_W-1:0]  msg_vector,
    input logic [MODE_W-1:0] msg_mode,
    input logic              msg_trig,
    input logic              msg_level,
    input logic [SH_W-1:0]   msg_short,
    input logic              drop_err
);
    logic lo_wr;
    assign lo_wr = reg_we && (reg_addr == OFF_LO);

    // R3
    launch_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !msg_valid) |=> (msg_valid && !drop_err));

    // R5
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest) && $stable(msg_vector)
            && $stable(msg_mode) && $stable(msg_trig) && $stable(msg_level) && $stable(msg_short)));

    // R7
    busy_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && msg_valid) |=> drop_err);

    // R4
    self_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_short == SH_SELF) |-> (msg_dest == self_id));

    // R4
    bcast_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_short[1]) |-> (msg_dest == ID_BCAST));
endmodule

bind ipi_cmd_unit ipi_cmd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .self_id(self_id), .reg_we(reg_we), .reg_addr(reg_addr),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_trig(msg_trig),
    .msg_level(msg_level), .msg_short(msg_short), .drop_err(drop_err)
);

// File: tb/ipi_cmd_unit_tb.sv
`timescale 1ns/100ps
module ipi_cmd_unit_tb;
    localparam logic [11:0] A_LO = 12'h300;
    localparam logic [11:0] A_HI = 12'h310;
    localparam logic [7:0]  SELF = 8'h05;

    logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, msg_ready = 1'b0;
    logic [7:0]  self_id = SELF;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        msg_valid, msg_trig, msg_level, drop_err;
    logic [7:0]  msg_dest, msg_vector;
    logic [2:0]  msg_mode;
    logic [1:0]  msg_short;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    ipi_cmd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .self_id(self_id), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_trig(msg_trig), .msg_level(msg_level),
        .msg_short(msg_short), .drop_err(drop_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] lo_word(input logic [1:0] sh, input logic [1:0] rr,
        input logic trig, input logic lv, input logic busy, input logic [2:0] md, input logic [7:0] v);
        return {12'h0, sh, rr, trig, lv, 1'b0, busy, 1'b0, md, v};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [2:0] modes [5] = '{3'b000, 3'b100, 3'b101, 3'b110, 3'b011};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 valid", 32'(msg_valid), 0);
        chk("R1 err", 32'(drop_err), 0);
        rd(A_LO, r); chk("R1 lo", r, 0);
        rd(A_HI, r); chk("R1 hi", r, 0);
        // R2 unmapped offset
        rd(12'h320, r); chk("R2 other", r, 0);

        for (int sh = 0; sh < 4; sh++) begin
            for (int mi = 0; mi < 5; mi++) begin
                for (int lv = 0; lv < 2; lv++) begin
                    logic [7:0] hid, vec, edest;
                    logic [2:0] md;
                    logic tg;
                    logic [1:0] rr_p, rr_d;
                    int lat;
                    hid = 8'(8'h10 + sh * 16 + mi);
                    vec = 8'(sh * 40 + mi * 7 + lv * 3 + 16);
                    md  = modes[mi];
                    tg  = md[0];
                    lat = (sh + mi + lv) % 3;
                    edest = (sh == 0) ? hid : (sh == 1) ? SELF : 8'hFF;
                    rr_p = (md == 3'b011) ? 2'b01 : 2'b00;
                    rr_d = (md == 3'b011) ? 2'b10 : 2'b00;

                    wr(A_HI, {hid, 24'hABCDEF});
                    rd(A_HI, r); chk("R2 hi readback", r, {hid, 24'h0});

                    wr(A_LO, lo_word(2'(sh), 2'b00, tg, 1'(lv), 1'b0, md, vec));
                    // R3 launch and field mapping
                    chk("R3 valid", 32'(msg_valid), 1);
                    chk("R3 vector", 32'(msg_vector), 32'(vec));
                    chk("R3 mode", 32'(msg_mode), 32'(md));
                    chk("R3 trig/level", {30'h0, msg_trig, msg_level}, {30'h0, tg, 1'(lv)});
                    chk("R4 dest", 32'(msg_dest), 32'(edest));
                    chk("R4 short", 32'(msg_short), 32'(sh));
                    chk("R7 err cleared by launch", 32'(drop_err), 0);
                    // R5 R9 R11 readback while busy
                    rd(A_LO, r);
                    chk("R11 R5 R9 lo busy", r, lo_word(2'(sh), rr_p, tg, 1'(lv), 1'b1, md, vec));

                    if (lat >= 1) begin
                        wr(A_HI, {8'hEE, 24'h0});
                        chk("R8 dest kept", 32'(msg_dest), 32'(edest));
                        chk("R6 still valid", 32'(msg_valid), 1);
                    end
                    if (lat == 2) begin
                        wr(A_LO, lo_word(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 3'b000, 8'h77));
                        chk("R7 err set", 32'(drop_err), 1);
                        chk("R7 vector kept", 32'(msg_vector), 32'(vec));
                        chk("R7 mode kept", 32'(msg_mode), 32'(md));
                    end

                    msg_ready = 1'b1;
                    @(negedge clk);
                    msg_ready = 1'b0;
                    chk("R5 valid cleared", 32'(msg_valid), 0);
                    rd(A_LO, r);
                    chk("R5 R9 lo done", r, lo_word(2'(sh), rr_d, tg, 1'(lv), 1'b0, md, vec));
                    chk("R7 err sticky", 32'(drop_err), (lat == 2) ? 1 : 0);
                end
            end
        end

        // R10 startup: start address 0x9A000 gives page 0x9A
        begin
            logic [31:0] start_addr;
            logic [7:0]  page;
            start_addr = 32'h0009_A000;
            page = 8'(start_addr / 4096);
            wr(A_HI, {8'h03, 24'h0});
            wr(A_LO, lo_word(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 3'b110, page));
            chk("R10 page vector", 32'(msg_vector), 32'h9A);
            chk("R10 dest", 32'(msg_dest), 32'h03);
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
            chk("R10 sent", 32'(msg_valid), 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule